// File: doc/BRIEF.md
# MASH 1-1-1 divider-ratio modulator

This block produces the instantaneous divide ratio for the multimodulus divider of a fractional-N frequency synthesizer. It receives a coarse integer divide word and a fine fractional word. Once per divider output cycle it emits an integer ratio whose long-run average equals the integer word plus the fraction divided by 2^FRAC_W. The block dithers the ratio around that value. The resulting quantization noise is pushed to high offsets, where the loop filter removes it.

Three identical first-order accumulator stages are cascaded. Only the first stage sees the fractional word. Each later stage accumulates the fresh residue of the stage before it. The carries are recombined in one step: the second stage's carry passes through a first difference and the third stage's carry through a second difference. Only the third stage's quantization error remains, and it is shaped by (1 - z^-1)^3. The integer word is added after recombination. The result is saturated to the range the divider accepts, and a sticky flag records any clamping. All state advances only on the clock edges where the divider-derived enable is high.

Top module: `mash111_ratio_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all three accumulator residues and the carry history, sets `ratio` to 64 and clears `clamp_seen`.
- R2: Each stage forms a 7-bit sum of its 6-bit residue and its addend. Bit 6 of that sum is the stage carry and bits 5:0 become the new residue. Stage 1 adds `frac_word`, stage 2 adds stage 1's new residue, and stage 3 adds stage 2's new residue, all within the same sample.
- R3: The unclamped ratio of a sample is I + c1 + (c2 - c2') + (c3 - 2*c3' + c3''). Here ' marks the value from the previous enabled sample and '' the value from the one before. Both are zero just after reset.
- R4: The summed modulator correction (unclamped ratio minus I) always lies within -3 to +4.
- R5: On edges where `step_en` is low, `ratio`, `clamp_seen` and all internal state hold their values whatever `frac_word` and `int_word` do.
- R6: `ratio` is registered. The value for a sample appears just after the enabled edge that computes it.
- R7: With `frac_word` = 0 after reset, every sample gives `ratio` equal to `int_word`.
- R8: Over 4096 consecutive samples after reset, the mean of `ratio` equals `int_word` + `frac_word`/64 within 1/64, when no clamping occurs.
- R9: `ratio` is saturated to the range 64 to 127 inclusive.
- R10: `clamp_seen` rises after any enabled sample whose unclamped ratio lies outside 64 to 127. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | One-cycle enable per divider output period |
| int_word | input | 7 | Integer part of the divide ratio |
| frac_word | input | 6 | Fractional part, in units of 1/64 |
| ratio | output | 7 | Divide ratio for the current divider period |
| clamp_seen | output | 1 | Sticky flag: saturation has occurred since reset |

## Verification
A zero fraction checks that the recombined carries cancel completely and the ratio sits at the integer word. The fractions 1, 32 and 63 exercise the sparsest, most regular and densest carry patterns; each checks the second-difference history separately from the first stage alone. Random integer and fraction pairs are compared sample by sample against a bench model of the three stages, and their 4096-sample means against the target ratio. Integer words at 64 and 127 with a large fraction drive the correction past both limits to exercise saturation and the sticky flag. Stretches with the enable low show that nothing advances between divider periods.

// File: rtl/mash_pkg.sv
package mash_pkg;

  // Delayed carries needed by the difference filters
  typedef struct packed {
    logic c2_d;
    logic c3_d;
    logic c3_dd;
  } carry_hist_t;

  // Sum of stage 1 carry, first difference of stage 2, second difference of stage 3
  function automatic int mash_corr(input logic c1, input logic c2, input logic c3,
                                   input carry_hist_t h);
    int v;
    v = int'(c1);
    v = v + int'(c2) - int'(h.c2_d);
    v = v + int'(c3) - 2 * int'(h.c3_d) + int'(h.c3_dd);
    return v;
  endfunction

  // Saturate a signed ratio to [lo, hi]
  function automatic int sat_ratio(input int raw, input int lo, input int hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] addend,
  output logic [W-1:0] residue_next,
  output logic         carry
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum_w;

  always_comb begin
    sum_w        = {1'b0, acc_q} + {1'b0, addend};
    carry        = sum_w[W];
    residue_next = sum_w[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= residue_next;
  end
endmodule

// File: rtl/mash_recombine.sv
module mash_recombine
  import mash_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        carries,
  output logic signed [3:0] corr
);
  carry_hist_t hist_q;

  always_comb corr = 4'(mash_corr(carries[0], carries[1], carries[2], hist_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (en) begin
      hist_q.c2_d  <= carries[1];
      hist_q.c3_d  <= carries[2];
      hist_q.c3_dd <= hist_q.c3_d;
    end
  end

  // R4
  corr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (corr >= -4'sd3) && (corr <= 4'sd4));
endmodule

// File: rtl/mash_ratio_limit.sv
module mash_ratio_limit
  import mash_pkg::*;
#(
  parameter int INT_W     = 7,
  parameter int RATIO_MIN = 64,
  parameter int RATIO_MAX = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INT_W-1:0]  int_word,
  input  logic signed [3:0] corr,
  output logic [INT_W-1:0]  ratio,
  output logic              clamp_seen
);
  localparam int RAW_W = INT_W + 2;

  logic signed [RAW_W-1:0] raw_ratio;
  logic                    raw_oor;

  always_comb begin
    raw_ratio = $signed({2'b00, int_word}) + $signed({{(RAW_W-4){corr[3]}}, corr});
    raw_oor   = (int'(raw_ratio) < RATIO_MIN) || (int'(raw_ratio) > RATIO_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio      <= INT_W'(RATIO_MIN);
      clamp_seen <= 1'b0;
    end else if (en) begin
      ratio      <= INT_W'(sat_ratio(int'(raw_ratio), RATIO_MIN, RATIO_MAX));
      clamp_seen <= clamp_seen | raw_oor;
    end
  end

  // R9
  ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(ratio) >= RATIO_MIN) && (int'(ratio) <= RATIO_MAX));

  // R10
  clamp_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en && raw_oor) |=> clamp_seen);

  // R10
  clamp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    clamp_seen |=> clamp_seen);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(ratio) && $stable(clamp_seen)));
endmodule

// File: rtl/mash111_ratio_mod.sv
module mash111_ratio_mod #(
  parameter int FRAC_W    = 6,
  parameter int INT_W     = 7,
  parameter int RATIO_MIN = 64,
  parameter int RATIO_MAX = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [INT_W-1:0]  int_word,
  input  logic [FRAC_W-1:0] frac_word,
  output logic [INT_W-1:0]  ratio,
  output logic              clamp_seen
);
  localparam int N_STAGES = 3;

  logic [FRAC_W-1:0]   stage_in  [N_STAGES];
  logic [FRAC_W-1:0]   stage_res [N_STAGES];
  logic [N_STAGES-1:0] stage_cy;
  logic signed [3:0]   corr_w;

  assign stage_in[0] = frac_word;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    if (k > 0) begin : g_link
      assign stage_in[k] = stage_res[k-1];
    end
    mash_acc_stage #(.W(FRAC_W)) acc_i (
      .clk         (clk),
      .rst         (rst),
      .en          (step_en),
      .addend      (stage_in[k]),
      .residue_next(stage_res[k]),
      .carry       (stage_cy[k])
    );
  end

  mash_recombine recomb_i (
    .clk    (clk),
    .rst    (rst),
    .en     (step_en),
    .carries(stage_cy),
    .corr   (corr_w)
  );

  mash_ratio_limit #(
    .INT_W    (INT_W),
    .RATIO_MIN(RATIO_MIN),
    .RATIO_MAX(RATIO_MAX)
  ) limit_i (
    .clk       (clk),
    .rst       (rst),
    .en        (step_en),
    .int_word  (int_word),
    .corr      (corr_w),
    .ratio     (ratio),
    .clamp_seen(clamp_seen)
  );

  // R7
  zero_frac_chk: assert property (@(posedge clk) disable iff (rst)
    (frac_word == '0 && stage_res[0] == '0 && stage_res[1] == '0 && stage_res[2] == '0)
      |-> (stage_cy == '0));
endmodule

// File: tb/mash111_ratio_mod_tb.sv
module mash111_ratio_mod_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [6:0] int_word = 7'd100;
  logic [5:0] frac_word = 6'd0;
  logic [6:0] ratio;
  logic       clamp_seen;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench model state
  int m_r1, m_r2, m_r3, m_p2, m_p3, m_pp3;
  bit m_clamp;
  int m_raw;

  always #10 clk = ~clk;

  mash111_ratio_mod dut_i (
    .clk(clk), .rst(rst), .step_en(step_en), .int_word(int_word),
    .frac_word(frac_word), .ratio(ratio), .clamp_seen(clamp_seen)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_r1 = 0; m_r2 = 0; m_r3 = 0; m_p2 = 0; m_p3 = 0; m_pp3 = 0; m_clamp = 0;
  endfunction

  // returns expected (saturated) ratio; leaves unclamped value in m_raw
  function automatic int model_step(input int iw, input int fw);
    int t, k1, k2, k3, y;
    t = m_r1 + fw;  k1 = t / 64; m_r1 = t % 64;
    t = m_r2 + m_r1; k2 = t / 64; m_r2 = t % 64;
    t = m_r3 + m_r2; k3 = t / 64; m_r3 = t % 64;
    y = iw + k1 + k2 - m_p2 + k3 - 2 * m_p3 + m_pp3;
    m_pp3 = m_p3; m_p3 = k3; m_p2 = k2;
    m_raw = y;
    if (y < 64 || y > 127) m_clamp = 1;
    if (y < 64) return 64;
    if (y > 127) return 127;
    return y;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; step_en = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  // one enabled sample; checks ratio right after the edge (R3, R6)
  task automatic step(input int iw, input int fw, input string req, output int got);
    int e;
    @(negedge clk); int_word = 7'(iw); frac_word = 6'(fw); step_en = 1'b1;
    e = model_step(iw, fw);
    @(posedge clk); #2;
    step_en = 1'b0;
    got = int'(ratio);
    check(req, got, e);
  endtask

  // runs 4096 samples from reset; checks each sample and the mean (R8)
  task automatic run_block(input int iw, input int fw, input bit mean_chk);
    longint sum = 0;
    longint err;
    int got;
    do_reset();
    for (int n = 0; n < 4096; n++) begin
      step(iw, fw, "R2/R3/R6 model", got);
      sum += got;
      if (mean_chk) check("R4 correction range", int'(m_raw >= iw - 3 && m_raw <= iw + 4), 1);
    end
    if (mean_chk) begin
      err = sum * 64 - longint'(4096) * (64 * iw + fw);
      if (err < 0) err = -err;
      check("R8 mean within 1/64", int'(err <= 4096), 1);
    end
  endtask

  initial begin
    int got, held;
    // R1 reset state
    do_reset();
    #2;
    check("R1 reset ratio", int'(ratio), 64);
    check("R1 reset clamp_seen", int'(clamp_seen), 0);

    // R7 zero fraction gives the integer word
    for (int n = 0; n < 20; n++) begin
      step(100, 0, "R7 zero fraction", got);
      check("R7 ratio equals int_word", got, 100);
    end

    // R5 hold while enable low
    step(95, 37, "R3 model", got);
    held = got;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk); int_word = 7'(70 + n); frac_word = 6'(n * 5); step_en = 1'b0;
      @(posedge clk); #2;
      check("R5 ratio held", int'(ratio), held);
    end
    // state untouched: next sample continues the model sequence
    step(95, 37, "R5 state held", got);

    // directed fractions
    run_block(86, 1, 1'b1);
    run_block(108, 63, 1'b1);
    run_block(100, 32, 1'b1);
    // constrained random pairs
    begin
      int s;
      s = $urandom(32'h5eed_1234);
      for (int p = 0; p < 3; p++) begin
        int iw, fw;
        iw = 86 + int'($urandom_range(22));
        fw = int'($urandom_range(63));
        run_block(iw, fw, 1'b1);
      end
    end

    // R9/R10 low saturation
    do_reset();
    for (int n = 0; n < 200; n++) step(64, 63, "R9 low clamp", got);
    check("R9 ratio not below 64", int'(got >= 64), 1);
    check("R10 clamp_seen set", int'(clamp_seen), int'(m_clamp));
    check("R10 clamp expected", int'(m_clamp), 1);
    for (int n = 0; n < 10; n++) step(100, 0, "R3 model", got);
    check("R10 clamp_seen sticky", int'(clamp_seen), 1);
    do_reset();
    #2;
    check("R1 reset clears clamp_seen", int'(clamp_seen), 0);

    // R9/R10 high saturation
    for (int n = 0; n < 200; n++) step(127, 63, "R9 high clamp", got);
    check("R9 ratio not above 127", int'(got <= 127), 1);
    check("R10 clamp_seen set high", int'(clamp_seen), 1);

    // R1 residues cleared: zero fraction after reset is flat
    do_reset();
    for (int n = 0; n < 8; n++) begin
      step(90, 0, "R1 residues cleared", got);
      check("R1 flat after reset", got, 90);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule